// File: doc/BRIEF.md
# Binary/Decimal Adder-Subtractor

This block is the arithmetic core for add-with-carry and subtract-with-borrow on 8-bit operands. A mode input selects plain binary or packed-BCD arithmetic. One adder serves both modes. In decimal mode each 4-bit digit is corrected as it leaves its slice, and the digit carry passes into the next slice, so a two-digit BCD operand gives a two-digit BCD result with a decimal carry.

Subtraction is done as A + ~B + carry-in. A carry-in of 1 means no borrow is pending. A carry-out of 0 means the subtraction borrowed. Software can therefore chain multi-byte subtractions through the carry, just as it chains additions.

The block computes the result and the flags in one combinational pass. Both are captured in an output register on each clock edge, so the outputs reflect the inputs present at the previous rising edge. In decimal mode only the result and the carry are defined. The zero, negative and overflow outputs carry no meaning there.

Top module: `bcd_addsub_alu`

## Requirements
- R1: A synchronous active-high reset clears every output (result, carry, overflow, zero, negative) to 0. Out of reset, the outputs show the function of the inputs sampled at the previous rising clock edge (one cycle of latency).
- R2: Binary add. When the mode input is 0 and the operation select is 0, the concatenation {carry, result} equals A + B + carry-in.
- R3: Binary subtract. When the mode input is 0 and the operation select is 1, the result is (A + ~B + carry-in) mod 256. The carry output is 1 exactly when A >= B + (1 - carry-in), treating the operands as unsigned; 1 means no borrow.
- R4: Overflow in binary mode. The overflow output is 1 exactly when the operation, taken on two's-complement operands, gives a true result outside -128..+127. For subtraction the true result is A - B - (1 - carry-in).
- R5: In binary mode, the zero output is 1 exactly when the 8-bit result is 0. The negative output equals bit 7 of the result.
- R6: Decimal add. With the mode input at 1, the operation select at 0 and BCD operands (bits 7:4 tens digit, bits 3:0 units digit, each 0..9), the result is the BCD form of (A + B + carry-in) mod 100. The carry output is 1 when that sum exceeds 99.
- R7: Decimal subtract. With the mode input at 1, the operation select at 1 and BCD operands, the result is the BCD form of (A - B - (1 - carry-in)) mod 100. The carry output is 1 when that difference is not negative.
- R8: Decimal correction works per digit and carries across the digit boundary. A units digit that passes 9 yields a units digit of (sum - 10) and increments the tens digit; a units digit that borrows yields (difference + 10) and decrements the tens digit. For example, 0x08 + 0x08 gives 0x16 and 0x10 - 0x01 gives 0x09.
- R9: Operation select encoding: 0 is add, 1 is subtract. Mode encoding: 0 is binary, 1 is decimal. For example, 0x09 + 0x01 gives 0x0A in binary mode and 0x10 in decimal mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_sub_i | input | 1 | Operation select: 0 add, 1 subtract |
| dec_mode_i | input | 1 | Arithmetic mode: 0 binary, 1 packed BCD |
| carry_i | input | 1 | Carry-in (for subtract: 1 means no borrow) |
| opa_i | input | 8 | First operand (minuend for subtract) |
| opb_i | input | 8 | Second operand (subtrahend for subtract) |
| sum_o | output | 8 | Registered result |
| carry_o | output | 1 | Registered carry-out / not-borrow |
| ovf_o | output | 1 | Registered signed overflow (binary mode only) |
| zero_o | output | 1 | Registered zero flag (binary mode only) |
| neg_o | output | 1 | Registered negative flag (binary mode only) |

## Verification
The decimal-mode assertions are guarded by a check that both sampled operands are valid packed BCD. They claim nothing about non-BCD operands, and they never check zero, negative or overflow in decimal mode. The binary-mode assertions assume no limits on the operands. Every assertion skips the first edge after reset, because the outputs there still hold the cleared value and not a function of the inputs. The stimulus builds each decimal operand from two digits drawn independently from 0..9, so decimal vectors never leave the defined domain. Binary vectors use the full 8-bit range with both carry-in values.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int unsigned BCD_DIGIT_W = 4;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } alu_op_e;

endpackage

// File: rtl/bcd_digit_slice.sv
module bcd_digit_slice
  import alu_pkg::*;
#(
  parameter int unsigned DW = BCD_DIGIT_W
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          c_i,
  input  logic          sub_i,
  input  logic          dec_i,
  output logic [DW-1:0] d_o,
  output logic          c_o
);

  // largest legal decimal digit and the two correction constants
  localparam logic [DW:0]   DEC_LIMIT = (DW+1)'(9);
  localparam logic [DW-1:0] ADD_FIX   = DW'(6);
  localparam logic [DW-1:0] SUB_FIX   = DW'(10);

  logic [DW-1:0] b_eff;
  logic [DW:0]   raw;
  logic          add_fix;

  always_comb begin
    b_eff   = sub_i ? ~b_i : b_i;
    raw     = {1'b0, a_i} + {1'b0, b_eff} + {{DW{1'b0}}, c_i};
    add_fix = (raw > DEC_LIMIT);
    d_o     = raw[DW-1:0];
    c_o     = raw[DW];
    if (dec_i) begin
      if (sub_i) begin
        // no carry out of the slice means this digit borrowed
        if (!raw[DW]) begin
          d_o = raw[DW-1:0] + SUB_FIX;
        end
      end else begin
        c_o = add_fix;
        if (add_fix) begin
          d_o = raw[DW-1:0] + ADD_FIX;
        end
      end
    end
  end

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit #(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [DW-1:0] res_i,
  input  logic          sub_i,
  output logic          ovf_o,
  output logic          zero_o,
  output logic          neg_o
);

  localparam int unsigned MSB = DW - 1;

  logic b_sign;

  always_comb begin
    b_sign = sub_i ? ~b_i[MSB] : b_i[MSB];
    // same-signed operands producing an opposite-signed result
    ovf_o  = (a_i[MSB] == b_sign) && (res_i[MSB] != a_i[MSB]);
    zero_o = (res_i == '0);
    neg_o  = res_i[MSB];
  end

endmodule

// File: rtl/bcd_addsub_alu.sv
module bcd_addsub_alu
  import alu_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_sub_i,
  input  logic              dec_mode_i,
  input  logic              carry_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              carry_o,
  output logic              ovf_o,
  output logic              zero_o,
  output logic              neg_o
);

  localparam int unsigned DIGITS = DATA_W / BCD_DIGIT_W;

  alu_op_e           op;
  logic              is_sub;
  logic [DIGITS:0]   chain;
  logic [DATA_W-1:0] res_c;
  logic              ovf_c;
  logic              zero_c;
  logic              neg_c;

  assign op       = alu_op_e'(op_sub_i);
  assign is_sub   = (op == OP_SUB);
  assign chain[0] = carry_i;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    bcd_digit_slice #(
      .DW (BCD_DIGIT_W)
    ) slice_i (
      .a_i   (opa_i[g*BCD_DIGIT_W +: BCD_DIGIT_W]),
      .b_i   (opb_i[g*BCD_DIGIT_W +: BCD_DIGIT_W]),
      .c_i   (chain[g]),
      .sub_i (is_sub),
      .dec_i (dec_mode_i),
      .d_o   (res_c[g*BCD_DIGIT_W +: BCD_DIGIT_W]),
      .c_o   (chain[g+1])
    );
  end

  alu_flag_unit #(
    .DW (DATA_W)
  ) flags_i (
    .a_i    (opa_i),
    .b_i    (opb_i),
    .res_i  (res_c),
    .sub_i  (is_sub),
    .ovf_o  (ovf_c),
    .zero_o (zero_c),
    .neg_o  (neg_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_o   <= '0;
      carry_o <= 1'b0;
      ovf_o   <= 1'b0;
      zero_o  <= 1'b0;
      neg_o   <= 1'b0;
    end else begin
      sum_o   <= res_c;
      carry_o <= chain[DIGITS];
      ovf_o   <= ovf_c;
      zero_o  <= zero_c;
      neg_o   <= neg_c;
    end
  end

endmodule

// File: rtl/bcd_addsub_alu_chk.sv
module bcd_addsub_alu_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              op_sub_i,
  input logic              dec_mode_i,
  input logic              carry_i,
  input logic [DATA_W-1:0] opa_i,
  input logic [DATA_W-1:0] opb_i,
  input logic [DATA_W-1:0] sum_o,
  input logic              carry_o,
  input logic              ovf_o,
  input logic              zero_o,
  input logic              neg_o
);

  localparam int unsigned NDIG = DATA_W / 4;

  function automatic logic is_bcd(input logic [DATA_W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < NDIG; i++) begin
      if (v[i*4 +: 4] > 4'd9) ok = 1'b0;
    end
    return ok;
  endfunction

  function automatic longint bcd_val(input logic [DATA_W-1:0] v);
    longint acc;
    acc = 0;
    for (int i = NDIG - 1; i >= 0; i--) begin
      acc = acc * 10 + longint'(v[i*4 +: 4]);
    end
    return acc;
  endfunction

  function automatic longint dec_limit();
    longint lim;
    lim = 1;
    for (int i = 0; i < NDIG; i++) lim = lim * 10;
    return lim;
  endfunction

  function automatic logic ovf_ref(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b,
                                   input logic c, input logic sub);
    longint sa, sb, s, hi, lo;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    s  = sub ? (sa - sb - 1 + longint'(c)) : (sa + sb + longint'(c));
    hi = (longint'(1) <<< (DATA_W - 1)) - 1;
    lo = -(longint'(1) <<< (DATA_W - 1));
    return (s > hi) || (s < lo);
  endfunction

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> (sum_o == '0 && !carry_o && !ovf_o && !zero_o && !neg_o)); // R1

  AST_BIN_ADD_SUM: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && !$past(dec_mode_i) && !$past(op_sub_i)) |-> ({carry_o, sum_o} == ({1'b0, $past(opa_i)} + {1'b0, $past(opb_i)} + (DATA_W+1)'($past(carry_i))))); // R2

  AST_BIN_SUB_DIFF: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && !$past(dec_mode_i) && $past(op_sub_i)) |-> ({carry_o, sum_o} == ({1'b0, $past(opa_i)} + {1'b0, ~$past(opb_i)} + (DATA_W+1)'($past(carry_i))))); // R3

  AST_SIGNED_OVERFLOW: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && !$past(dec_mode_i)) |-> (ovf_o == ovf_ref($past(opa_i), $past(opb_i), $past(carry_i), $past(op_sub_i)))); // R4

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && !$past(dec_mode_i)) |-> (zero_o == (sum_o == '0))); // R5

  AST_NEG_FLAG: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && !$past(dec_mode_i)) |-> (neg_o == sum_o[DATA_W-1])); // R5

  AST_DEC_ADD_CARRY: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && $past(dec_mode_i) && !$past(op_sub_i) && is_bcd($past(opa_i)) && is_bcd($past(opb_i))) |-> (carry_o == ((bcd_val($past(opa_i)) + bcd_val($past(opb_i)) + longint'($past(carry_i))) >= dec_limit()))); // R6

  AST_DEC_SUB_CARRY: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && $past(dec_mode_i) && $past(op_sub_i) && is_bcd($past(opa_i)) && is_bcd($past(opb_i))) |-> (carry_o == ((bcd_val($past(opa_i)) - bcd_val($past(opb_i)) - 1 + longint'($past(carry_i))) >= 0))); // R7

  AST_DEC_DIGITS_LEGAL: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && $past(dec_mode_i) && is_bcd($past(opa_i)) && is_bcd($past(opb_i))) |-> is_bcd(sum_o)); // R8

endmodule

bind bcd_addsub_alu bcd_addsub_alu_chk #(
  .DATA_W (DATA_W)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .op_sub_i   (op_sub_i),
  .dec_mode_i (dec_mode_i),
  .carry_i    (carry_i),
  .opa_i      (opa_i),
  .opb_i      (opb_i),
  .sum_o      (sum_o),
  .carry_o    (carry_o),
  .ovf_o      (ovf_o),
  .zero_o     (zero_o),
  .neg_o      (neg_o)
);

// File: tb/bcd_addsub_alu_tb_top.sv
`timescale 1ns/1ps
module bcd_addsub_alu_tb_top;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         op_sub_i = 1'b0;
  logic         dec_mode_i = 1'b0;
  logic         carry_i = 1'b0;
  logic [W-1:0] opa_i = '0;
  logic [W-1:0] opb_i = '0;
  logic [W-1:0] sum_o;
  logic         carry_o, ovf_o, zero_o, neg_o;

  int n_vec = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  bcd_addsub_alu #(.DATA_W(W)) dut_i (
    .clk(clk), .rst(rst), .op_sub_i(op_sub_i), .dec_mode_i(dec_mode_i),
    .carry_i(carry_i), .opa_i(opa_i), .opb_i(opb_i), .sum_o(sum_o),
    .carry_o(carry_o), .ovf_o(ovf_o), .zero_o(zero_o), .neg_o(neg_o)
  );

  function automatic int from_bcd(input logic [7:0] v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  function automatic logic [7:0] to_bcd(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  task automatic fail(input string tag, input string what, input int act, input int exp);
    n_bad++;
    $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
  endtask

  task automatic apply(input logic [7:0] a, input logic [7:0] b, input logic c,
                       input logic sub, input logic dec, input string tag);
    logic [7:0] er;
    logic       ec, ev, ez, en;
    int         s, sa, sb, ss;
    @(negedge clk);
    opa_i = a; opb_i = b; carry_i = c; op_sub_i = sub; dec_mode_i = dec;
    if (!dec) begin
      s  = sub ? int'(a) + (255 - int'(b)) + int'(c) : int'(a) + int'(b) + int'(c);
      er = 8'(s % 256);
      ec = (s > 255);
      sa = (a > 127) ? int'(a) - 256 : int'(a);
      sb = (b > 127) ? int'(b) - 256 : int'(b);
      ss = sub ? sa - sb - 1 + int'(c) : sa + sb + int'(c);
      ev = (ss > 127) || (ss < -128);
      ez = (er == 8'h00);
      en = er[7];
    end else begin
      if (sub) begin
        s  = from_bcd(a) - from_bcd(b) - 1 + int'(c);
        ec = (s >= 0);
        er = to_bcd(s < 0 ? s + 100 : s);
      end else begin
        s  = from_bcd(a) + from_bcd(b) + int'(c);
        ec = (s > 99);
        er = to_bcd(s % 100);
      end
      ev = 1'b0; ez = 1'b0; en = 1'b0;
    end
    @(posedge clk);
    #1;
    n_vec++;
    if (sum_o !== er)   fail(tag, "result", int'(sum_o), int'(er));
    if (carry_o !== ec) fail(tag, "carry", int'(carry_o), int'(ec));
    if (!dec) begin
      if (ovf_o !== ev)  fail("R4", "overflow", int'(ovf_o), int'(ev));
      if (zero_o !== ez) fail("R5", "zero", int'(zero_o), int'(ez));
      if (neg_o !== en)  fail("R5", "negative", int'(neg_o), int'(en));
    end
  endtask

  task automatic check_reset_state();
    n_vec++;
    if ({sum_o, carry_o, ovf_o, zero_o, neg_o} !== '0)
      fail("R1", "reset outputs", int'({sum_o, carry_o, ovf_o, zero_o, neg_o}), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fail("R1", "watchdog expired", 200000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    // R1: reset clears the outputs even with live inputs
    opa_i = 8'h7F; opb_i = 8'h01; carry_i = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check_reset_state();
    @(negedge clk);
    rst = 1'b0;

    // R2 binary add
    apply(8'h00, 8'h00, 1'b0, 1'b0, 1'b0, "R2");
    apply(8'hFF, 8'h01, 1'b0, 1'b0, 1'b0, "R2");
    apply(8'h7F, 8'h01, 1'b0, 1'b0, 1'b0, "R2");
    apply(8'h80, 8'h80, 1'b0, 1'b0, 1'b0, "R2");
    apply(8'hFE, 8'h00, 1'b1, 1'b0, 1'b0, "R2");
    // R3 binary subtract
    apply(8'h05, 8'h03, 1'b1, 1'b1, 1'b0, "R3");
    apply(8'h03, 8'h05, 1'b1, 1'b1, 1'b0, "R3");
    apply(8'h00, 8'h00, 1'b0, 1'b1, 1'b0, "R3");
    apply(8'h80, 8'h01, 1'b1, 1'b1, 1'b0, "R3");
    apply(8'h44, 8'h44, 1'b1, 1'b1, 1'b0, "R3");
    // R6 decimal add
    apply(8'h45, 8'h38, 1'b0, 1'b0, 1'b1, "R6");
    apply(8'h99, 8'h01, 1'b0, 1'b0, 1'b1, "R6");
    apply(8'h50, 8'h50, 1'b1, 1'b0, 1'b1, "R6");
    apply(8'h99, 8'h99, 1'b1, 1'b0, 1'b1, "R6");
    // R7 decimal subtract
    apply(8'h00, 8'h01, 1'b1, 1'b1, 1'b1, "R7");
    apply(8'h46, 8'h12, 1'b0, 1'b1, 1'b1, "R7");
    apply(8'h12, 8'h12, 1'b1, 1'b1, 1'b1, "R7");
    apply(8'h00, 8'h00, 1'b0, 1'b1, 1'b1, "R7");
    // R8 digit correction across the nibble boundary
    apply(8'h08, 8'h08, 1'b0, 1'b0, 1'b1, "R8");
    apply(8'h09, 8'h00, 1'b1, 1'b0, 1'b1, "R8");
    apply(8'h10, 8'h01, 1'b1, 1'b1, 1'b1, "R8");
    apply(8'h40, 8'h05, 1'b1, 1'b1, 1'b1, "R8");
    // R9 same operands, different mode and operation codes
    apply(8'h09, 8'h01, 1'b0, 1'b0, 1'b0, "R9");
    apply(8'h09, 8'h01, 1'b0, 1'b0, 1'b1, "R9");
    apply(8'h09, 8'h01, 1'b1, 1'b1, 1'b0, "R9");

    // R1: reset asserted mid-run clears registered outputs
    @(negedge clk);
    rst = 1'b1; opa_i = 8'hFF; opb_i = 8'hFF; carry_i = 1'b1;
    @(posedge clk);
    #1;
    check_reset_state();
    @(negedge clk);
    rst = 1'b0;

    // random binary vectors, R2/R3
    for (int i = 0; i < 3000; i++) begin
      logic s;
      s = 1'($urandom_range(0, 1));
      apply(8'($urandom_range(0, 255)), 8'($urandom_range(0, 255)),
            1'($urandom_range(0, 1)), s, 1'b0, s ? "R3" : "R2");
    end
    // random decimal vectors from digits 0..9, R6/R7
    for (int i = 0; i < 3000; i++) begin
      logic s;
      s = 1'($urandom_range(0, 1));
      apply({4'($urandom_range(0, 9)), 4'($urandom_range(0, 9))},
            {4'($urandom_range(0, 9)), 4'($urandom_range(0, 9))},
            1'($urandom_range(0, 1)), s, 1'b1, s ? "R7" : "R6");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule